// File: doc/BRIEF.md
# Constrained Genotype Mutation Engine

This block runs the search loop of a one-parent, four-child evolution strategy over the genotype of a small feed-forward gate array. The genotype describes a grid of logic cells. Each cell has three connection genes and one function gene, and a short list of output-connection genes follows the cells. The engine holds the current parent. It builds four children in turn by copying the parent and overwriting a fixed number of randomly chosen genes. It offers each child to an outside evaluator and waits for a score. When a generation ends, the best-scoring genotype becomes the parent for the next one.

A new gene value is always drawn from the alphabet that is legal for that gene. A connection gene of a cell in column `c` may only name the cells of the `LEVELS_BACK` columns to its left, and may name primary inputs only while the input column lies inside that window. A function gene only takes a value from the allowed function set. An output gene may name any primary input or any cell. Every child is therefore a valid feed-forward circuit, and no repair step or legality filter is needed downstream.

A host loads a starting genotype through a write port, or asks for a random first generation. It then pulses `start`, answers each offered candidate with a fitness value, and reads the winning genotype back through the read port once `done` is high.

Top module: `gene_mutator`

## Requirements
- R1: After reset, `cand_valid`, `busy` and `done` are all low.
- R2: Genes are indexed `g = 4*cell + slot` with `cell = col*ROWS + row`. Slots 0 to 2 are connections and slot 3 is the function. The genes at `4*NCELL + k` are outputs. Labels 0 to `N_IN-1` are primary inputs, and label `N_IN + cell` is a cell output. Every connection gene of an offered candidate lies in `[lo, N_IN + col*ROWS)`. Here `lo` is 0 when `col < LEVELS_BACK`, and `N_IN + (col-LEVELS_BACK)*ROWS` otherwise.
- R3: Every function gene of an offered candidate is a value `v` in 0 to 20 with bit `v` of `FUNC_MASK` set.
- R4: Every output gene of an offered candidate is below `N_IN + NCELL`.
- R5: Each child differs from the parent of its generation in at most `NMUT = max(1, floor(NGENE*MUT_PCT/100))` genes.
- R6: Generation 0 offers five candidates. With `rand_init` high, all five are fully random legal genotypes. With `rand_init` low, the first candidate is the loaded genotype, unchanged, and the other four are children of it.
- R7: The first candidate of a run is always kept. After that, a candidate replaces the kept genotype when its fitness is greater than or equal to the kept fitness, so ties go to the later candidate. At the end of each generation, the kept genotype becomes the parent. After the run, `best_fit` and the genotype read with `rd_sel`=1 are the kept ones.
- R8: A run offers exactly `5 + 4*(GENERATIONS-1)` candidates. After that, `done` is high and `busy` is low.
- R9: An offered candidate stays valid and unchanged until the cycle in which `fit_valid` is sampled high. `cand_valid` is low in the following cycle.
- R10: Randomness comes from a 16-bit LFSR with taps 16, 14, 13 and 11, shifting left. A draw over `n` values takes `(r*n)>>16`. A zero seed is replaced by 16'hACE1, so a run seeded with 0 offers exactly the candidates of a run seeded with 16'hACE1. Different seeds give different runs.
- R11: The write port loads the parent only while `busy` is low. A write during a run has no effect on later children.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| rand_init | input | 1 | Generation 0 uses random genotypes instead of the loaded one |
| seed | input | 16 | LFSR seed, latched at start |
| wr_en | input | 1 | Parent gene write strobe (idle only) |
| wr_addr | input | AW | Gene index to write |
| wr_data | input | W | Gene value to write |
| rd_sel | input | 1 | 0 reads the offered candidate, 1 reads the kept genotype |
| rd_addr | input | AW | Gene index to read |
| rd_data | output | W | Gene value read (combinational) |
| cand_valid | output | 1 | A candidate is waiting for its fitness |
| fit_valid | input | 1 | Fitness for the offered candidate is present |
| fit_value | input | FW | Unsigned fitness value |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |
| best_fit | output | FW | Fitness of the kept genotype |

## Verification
The hardest case to reach from the ports is a write to the parent register that arrives in the middle of a run. If that write took effect, it would only show up later, inside a child built after the write and before the parent is replaced at the end of the generation. The bench drives a write that would plant a forbidden function value while it answers the first child of generation 1. It then checks that gene in the remaining three children of that generation. Tie-breaking is exercised with a fitness sequence that repeats equal scores inside a generation, so the kept genotype depends on the later candidate winning.

// File: rtl/gene_mutator.sv
`timescale 1ns/1ps
module gene_mutator #(
  parameter int ROWS = 7,
  parameter int COLS = 7,
  parameter int LEVELS_BACK = 4,
  parameter int N_IN = 48,
  parameter int N_OUT = 8,
  parameter logic [20:0] FUNC_MASK = 21'h10000,
  parameter int MUT_PCT = 1,
  parameter int GENERATIONS = 10000,
  parameter int FW = 16,
  localparam int NCELL = ROWS * COLS,
  localparam int NLABEL = N_IN + NCELL,
  localparam int NGENE = NCELL * 4 + N_OUT,
  localparam int W = ($clog2(NLABEL) > 5) ? $clog2(NLABEL) : 5,
  localparam int AW = $clog2(NGENE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rand_init,
  input  logic [15:0]   seed,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          cand_valid,
  input  logic          fit_valid,
  input  logic [FW-1:0] fit_value,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] best_fit
);

  function automatic int ones21(logic [20:0] m);
    int c = 0;
    for (int i = 0; i < 21; i++) c += int'(m[i]);
    return c;
  endfunction

  localparam int NMUT_RAW = NGENE * MUT_PCT / 100;
  localparam int NMUT = (NMUT_RAW < 1) ? 1 : NMUT_RAW;
  localparam int NFUNC = ones21(FUNC_MASK);
  localparam int GCW = $clog2(GENERATIONS) + 1;
  localparam int MCW = $clog2(NMUT) + 1;

  typedef enum logic [2:0] {S_IDLE, S_COPY, S_FILL, S_MIDX, S_MVAL, S_OFFER, S_ADV} state_t;

  function automatic int scale(logic [15:0] r, int n);
    return int'(({16'd0, r} * 32'(n)) >> 16);
  endfunction

  function automatic int pick_func(int k);
    int c = 0;
    int res = 0;
    for (int i = 0; i < 21; i++)
      if (FUNC_MASK[i]) begin
        if (c == k) res = i;
        c++;
      end
    return res;
  endfunction

  function automatic logic [W-1:0] draw(int g, logic [15:0] r);
    int lo, n, col;
    lo = 0;
    n = NLABEL;
    if (g < NCELL * 4) begin
      if (g % 4 == 3) return W'(pick_func(scale(r, NFUNC)));
      col = (g / 4) / ROWS;
      if (col < LEVELS_BACK) n = N_IN + col * ROWS;
      else begin
        lo = N_IN + (col - LEVELS_BACK) * ROWS;
        n = LEVELS_BACK * ROWS;
      end
    end
    return W'(lo + scale(r, n));
  endfunction

  state_t state;
  logic [15:0] lfsr;
  logic [GCW-1:0] gen;
  logic [2:0] cidx;
  logic [AW-1:0] gidx, midx;
  logic [MCW-1:0] mcnt;
  logic first_q, done_q, ri_q;
  logic [FW-1:0] best_fit_q;
  logic [NGENE-1:0][W-1:0] parent_q, cand_q, best_q;

  wire [15:0] lfsr_nx = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  wire last_cand = (gen == '0) ? (cidx == 3'd4) : (cidx == 3'd3);

  assign busy = (state != S_IDLE);
  assign done = done_q;
  assign cand_valid = (state == S_OFFER);
  assign best_fit = best_fit_q;
  assign rd_data = (int'(rd_addr) >= NGENE) ? '0 : (rd_sel ? best_q[rd_addr] : cand_q[rd_addr]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lfsr <= 16'hACE1;
      gen <= '0;
      cidx <= '0;
      gidx <= '0;
      midx <= '0;
      mcnt <= '0;
      first_q <= 1'b1;
      done_q <= 1'b0;
      ri_q <= 1'b0;
      best_fit_q <= '0;
      parent_q <= '0;
      cand_q <= '0;
      best_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wr_en && int'(wr_addr) < NGENE) parent_q[wr_addr] <= wr_data;
          if (start) begin
            lfsr <= (seed == 16'd0) ? 16'hACE1 : seed;
            gen <= '0;
            cidx <= '0;
            gidx <= '0;
            first_q <= 1'b1;
            done_q <= 1'b0;
            ri_q <= rand_init;
            state <= rand_init ? S_FILL : S_COPY;
          end
        end
        S_COPY: begin
          cand_q <= parent_q;
          mcnt <= '0;
          state <= (gen == '0 && cidx == '0) ? S_OFFER : S_MIDX;
        end
        S_FILL: begin
          cand_q[gidx] <= draw(int'(gidx), lfsr);
          lfsr <= lfsr_nx;
          gidx <= gidx + 1'b1;
          if (gidx == AW'(NGENE - 1)) state <= S_OFFER;
        end
        S_MIDX: begin
          midx <= AW'(scale(lfsr, NGENE));
          lfsr <= lfsr_nx;
          state <= S_MVAL;
        end
        S_MVAL: begin
          cand_q[midx] <= draw(int'(midx), lfsr);
          lfsr <= lfsr_nx;
          mcnt <= mcnt + 1'b1;
          state <= (mcnt == MCW'(NMUT - 1)) ? S_OFFER : S_MIDX;
        end
        S_OFFER: begin
          if (fit_valid) begin
            if (first_q || fit_value >= best_fit_q) begin
              best_q <= cand_q;
              best_fit_q <= fit_value;
              first_q <= 1'b0;
            end
            state <= S_ADV;
          end
        end
        S_ADV: begin
          gidx <= '0;
          if (last_cand) begin
            parent_q <= best_q;
            cidx <= '0;
            if (gen == GCW'(GENERATIONS - 1)) begin
              done_q <= 1'b1;
              state <= S_IDLE;
            end else begin
              gen <= gen + 1'b1;
              state <= S_COPY;
            end
          end else begin
            cidx <= cidx + 1'b1;
            state <= (gen == '0 && ri_q) ? S_FILL : S_COPY;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gene_mutator_chk.sv
`timescale 1ns/1ps
module gene_mutator_chk #(
  parameter int ROWS = 7,
  parameter int COLS = 7,
  parameter int LEVELS_BACK = 4,
  parameter int N_IN = 48,
  parameter int N_OUT = 8,
  parameter logic [20:0] FUNC_MASK = 21'h10000,
  parameter int FW = 16,
  localparam int NCELL = ROWS * COLS,
  localparam int NLABEL = N_IN + NCELL,
  localparam int NGENE = NCELL * 4 + N_OUT,
  localparam int W = ($clog2(NLABEL) > 5) ? $clog2(NLABEL) : 5
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cand_valid,
  input logic fit_valid,
  input logic [FW-1:0] best_fit,
  input logic first_q,
  input logic [NGENE-1:0][W-1:0] cand_q
);

  function automatic bit func_ok(logic [W-1:0] v);
    if (int'(v) > 20) return 1'b0;
    return FUNC_MASK[v[4:0]];
  endfunction

  for (genvar g = 0; g < NGENE; g++) begin : g_gene
    if (g >= NCELL * 4) begin : g_out
      p_out_label_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> int'(cand_q[g]) < NLABEL);
    end else if (g % 4 == 3) begin : g_fn
      p_func_allowed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> func_ok(cand_q[g]));
    end else begin : g_cn
      localparam int COL = (g / 4) / ROWS;
      localparam int LO = (COL < LEVELS_BACK) ? 0 : N_IN + (COL - LEVELS_BACK) * ROWS;
      localparam int HI = N_IN + COL * ROWS;
      p_conn_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (int'(cand_q[g]) >= LO && int'(cand_q[g]) < HI));
    end
  end

  p_hold_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !fit_valid) |=> (cand_valid && $stable(cand_q)));

  p_drop_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && fit_valid) |=> !cand_valid);

  p_best_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !first_q && $past(busy) && !$past(first_q)) |-> best_fit >= $past(best_fit));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cand_valid);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind gene_mutator gene_mutator_chk #(
  .ROWS(ROWS), .COLS(COLS), .LEVELS_BACK(LEVELS_BACK), .N_IN(N_IN),
  .N_OUT(N_OUT), .FUNC_MASK(FUNC_MASK), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cand_valid(cand_valid),
  .fit_valid(fit_valid), .best_fit(best_fit), .first_q(first_q), .cand_q(cand_q)
);

// File: tb/gene_mutator_tb.sv
`timescale 1ns/1ps
module gene_mutator_tb;
  localparam int ROWS = 2, COLS = 3, LB = 2, NIN = 3, NOUT = 2, PCT = 20, GENS = 5, FW = 16;
  localparam logic [20:0] FMASK = 21'h10408;
  localparam int NCELL = ROWS * COLS;
  localparam int NLABEL = NIN + NCELL;
  localparam int NGENE = NCELL * 4 + NOUT;
  localparam int W = ($clog2(NLABEL) > 5) ? $clog2(NLABEL) : 5;
  localparam int AW = $clog2(NGENE);
  localparam int NMUT = (NGENE * PCT / 100 < 1) ? 1 : NGENE * PCT / 100;
  localparam int NOFF = 5 + 4 * (GENS - 1);

  logic clk, rst_n, start, rand_init, wr_en, rd_sel, fit_valid;
  logic [15:0] seed;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [W-1:0] wr_data, rd_data;
  logic [FW-1:0] fit_value, best_fit;
  logic cand_valid, busy, done;

  gene_mutator #(.ROWS(ROWS), .COLS(COLS), .LEVELS_BACK(LB), .N_IN(NIN), .N_OUT(NOUT),
    .FUNC_MASK(FMASK), .MUT_PCT(PCT), .GENERATIONS(GENS), .FW(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rand_init(rand_init), .seed(seed),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .cand_valid(cand_valid), .fit_valid(fit_valid), .fit_value(fit_value),
    .busy(busy), .done(done), .best_fit(best_fit));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [W-1:0] arr [NGENE];
  logic [W-1:0] par [NGENE];
  logic [W-1:0] bst [NGENE];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lo_of(int g);
    int col = (g / 4) / ROWS;
    return (col < LB) ? 0 : NIN + (col - LB) * ROWS;
  endfunction

  function automatic int hi_of(int g);
    return NIN + ((g / 4) / ROWS) * ROWS;
  endfunction

  task automatic read_all(input bit sel);
    rd_sel = sel;
    for (int g = 0; g < NGENE; g++) begin
      rd_addr = AW'(g);
      #0.2;
      arr[g] = rd_data;
    end
  endtask

  task automatic run(input logic [15:0] sd, input bit ri, input bit do_write, output int unsigned hash);
    int off = 0;
    int bfit = 0;
    bit first = 1'b1;
    hash = 0;
    seed = sd;
    rand_init = ri;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (1) begin
      @(negedge clk);
      if (done || off > NOFF) break;
      if (cand_valid) begin
        int fit;
        int diff = 0;
        bit okc = 1, okf = 1, oko = 1;
        read_all(1'b0);
        for (int g = 0; g < NGENE; g++) begin
          hash = hash * 33 + int'(arr[g]);
          if (g >= NCELL * 4) oko &= (int'(arr[g]) < NLABEL);
          else if (g % 4 == 3) okf &= (int'(arr[g]) <= 20) && FMASK[arr[g][4:0]];
          else okc &= (int'(arr[g]) >= lo_of(g)) && (int'(arr[g]) < hi_of(g));
          if (arr[g] != par[g]) diff++;
        end
        chk(okc, "R2 connection window", off, 1);
        chk(okf, "R3 function set", off, 1);
        chk(oko, "R4 output range", off, 1);
        if (!ri && off == 0) chk(diff == 0, "R6 loaded genotype offered first", diff, 0);
        else if (!(ri && off < 5)) chk(diff <= NMUT, "R5 genes changed", diff, NMUT);
        if (do_write && off >= 6 && off <= 8)
          chk(arr[3] != '0, "R11 write ignored while busy", int'(arr[3]), 16);
        fit = (off % 4 == 3) ? 0 : off / 2;
        if (first || fit >= bfit) begin
          for (int g = 0; g < NGENE; g++) bst[g] = arr[g];
          bfit = fit;
          first = 1'b0;
        end
        fit_value = FW'(fit);
        fit_valid = 1'b1;
        if (do_write && off == 5) begin
          wr_en = 1'b1;
          wr_addr = AW'(3);
          wr_data = '0;
        end
        @(negedge clk);
        fit_valid = 1'b0;
        wr_en = 1'b0;
        chk(!cand_valid, "R9 offer drops after fitness", int'(cand_valid), 0);
        off++;
        if (off == 5 || (off > 5 && (off - 5) % 4 == 0))
          for (int g = 0; g < NGENE; g++) par[g] = bst[g];
      end
    end
    chk(off == NOFF, "R8 candidate count", off, NOFF);
    chk(done && !busy, "R8 done and idle", int'({done, busy}), 2);
    chk(int'(best_fit) == bfit, "R7 kept fitness", int'(best_fit), bfit);
    read_all(1'b1);
    begin
      int bad = 0;
      for (int g = 0; g < NGENE; g++) if (arr[g] != bst[g]) bad++;
      chk(bad == 0, "R7 kept genotype", bad, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned h0, h1, h2, h3;
    rst_n = 1'b0; start = 0; rand_init = 0; seed = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    rd_sel = 0; rd_addr = '0; fit_valid = 0; fit_value = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cand_valid && !busy && !done, "R1 reset state", int'({cand_valid, busy, done}), 0);

    run(16'h0000, 1'b1, 1'b0, h0);
    run(16'hACE1, 1'b1, 1'b0, h1);
    chk(h0 == h1, "R10 zero seed substitution", int'(h0), int'(h1));
    run(16'h1234, 1'b1, 1'b0, h2);
    chk(h0 != h2, "R10 seed changes run", int'(h2), int'(h0));

    for (int g = 0; g < NGENE; g++) begin
      if (g >= NCELL * 4) par[g] = W'(NLABEL - 1);
      else if (g % 4 == 3) par[g] = W'(16);
      else par[g] = W'(lo_of(g));
      wr_en = 1'b1;
      wr_addr = AW'(g);
      wr_data = par[g];
      @(negedge clk);
    end
    wr_en = 1'b0;
    run(16'h0BAD, 1'b0, 1'b1, h3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule